// File: doc/BRIEF.md
# Two-Wire Bus Slave Address Matcher

This block watches a two-wire serial bus (clock line and data line) and decides whether the first byte after a START condition addresses this device. It resynchronises both bus lines into the system clock domain and finds START and STOP conditions there. It shifts in the seven address bits and the direction bit, then compares the address with a programmed value. Any address bit can be left out of the comparison through a mask. As an option, the all-zero general call address can also be accepted.

When the address matches, the block drives the data line low for the ninth bus clock as an acknowledge. It also sets a sticky match flag, which is the interrupt request. When the address does not match, the block leaves the data line alone and takes no notice of the bus until the next START. Software configures the block through a byte-wide register port with three offsets and clears the status by writing to the status offset. Data bytes after the address phase are handled elsewhere.

Top module: `twb_addr_match`

## Requirements
- R1: After reset, offset 0 (own address) reads 0xFE, offset 1 (mask) reads 0x00 and offset 2 (status) reads 0x00; `sda_pull` and `irq` are low.
- R2: Offset 1 stores the mask in bits 7..1; bit 0 cannot be written and always reads 0.
- R3: If the received address (the first seven bits after START, MSB first, sampled on SCL rising edges) equals bits 7..1 of offset 0, the block asserts `sda_pull` only while SCL is low, holds it through the ninth SCL high phase, and raises `irq`.
- R4: If the received address does not match, `sda_pull` stays low during the ninth clock and `irq` stays low.
- R5: A mask bit at one in offset 1, bit k+1, makes address bit k count as matching whatever its received value.
- R6: If offset 0 bit 0 is one, a received address of 0x00 matches and sets status bit 2 (general call). If that bit is zero, 0x00 matches only through the own-address compare.
- R7: The eighth received bit is the direction. It is never compared, and it is copied into status bit 1 on a match. Status bit 0 is the match flag.
- R8: A START seen in the middle of an address byte (repeated START) releases `sda_pull` and restarts reception at the first address bit.
- R9: Writing any value to offset 2 clears all status bits and drops `irq`. A match in the same cycle takes priority.
- R10: After a mismatch, further bus clocks are ignored until the next START. An own-address byte sent without a new START is not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset: 0 own address, 1 mask, 2 status |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| scl_in | input | 1 | Bus clock line, asynchronous |
| sda_in | input | 1 | Bus data line as seen on the wire, asynchronous |
| sda_pull | output | 1 | 1 = pull the data line low (acknowledge) |
| irq | output | 1 | Interrupt request, equal to the status match flag |

## Verification
The bound checker watches the timing rules on every cycle. The acknowledge may only begin while the synchronised clock is low. It must coincide with a comparator hit, and it is dropped after any START. The mask register's low bit always reads zero. A status clear with no competing match always drops the interrupt. Whether a given address, mask and general-call setting leads to an acknowledge is a matter of data, so only the directed scenarios can show it. The same holds for the captured direction bit and the general-call flag, for restarting after a repeated START, and for ignoring the bus after a mismatch.

// File: rtl/twb_am_pkg.sv
package twb_am_pkg;
   typedef enum logic [1:0] {
      ST_IDLE,
      ST_ADDR,
      ST_WAIT,
      ST_ACK
   } am_state_e;

   localparam int OFS_OWN  = 0;
   localparam int OFS_MASK = 1;
   localparam int OFS_STAT = 2;

   localparam int STB_MATCH = 0;
   localparam int STB_DIR   = 1;
   localparam int STB_GC    = 2;
endpackage

// File: rtl/twb_am_front.sv
module twb_am_front #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   input  logic sda_in,
   output logic scl_s,
   output logic sda_s,
   output logic start_p,
   output logic stop_p,
   output logic scl_rise,
   output logic scl_fall
);
   logic [SYNC_STAGES-1:0] scl_chain, sda_chain;
   logic scl_d, sda_d;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("twb_am_front: SYNC_STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_chain <= '1;
         sda_chain <= '1;
         scl_d     <= 1'b1;
         sda_d     <= 1'b1;
      end else begin
         scl_chain <= {scl_chain[SYNC_STAGES-2:0], scl_in};
         sda_chain <= {sda_chain[SYNC_STAGES-2:0], sda_in};
         scl_d     <= scl_s;
         sda_d     <= sda_s;
      end
   end

   assign scl_s    = scl_chain[SYNC_STAGES-1];
   assign sda_s    = sda_chain[SYNC_STAGES-1];
   assign start_p  = scl_s & scl_d & sda_d & ~sda_s;
   assign stop_p   = scl_s & scl_d & ~sda_d & sda_s;
   assign scl_rise = scl_s & ~scl_d;
   assign scl_fall = ~scl_s & scl_d;
endmodule

// File: rtl/twb_am_cmp.sv
module twb_am_cmp #(
   parameter int ADDR_W     = 7,
   parameter bit GC_SUPPORT = 1'b1
) (
   input  logic [ADDR_W-1:0] own_addr,
   input  logic [ADDR_W-1:0] mask,
   input  logic              gc_en,
   input  logic [ADDR_W-1:0] rx_addr,
   output logic              own_hit,
   output logic              gc_hit
);
   logic [ADDR_W-1:0] bit_ok;

   generate
      for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
         assign bit_ok[i] = mask[i] | (rx_addr[i] == own_addr[i]);
      end
      if (GC_SUPPORT) begin : g_gc
         assign gc_hit = gc_en & (rx_addr == '0);
      end else begin : g_no_gc
         assign gc_hit = 1'b0;
      end
   endgenerate

   assign own_hit = &bit_ok;
endmodule

// File: rtl/twb_am_seq.sv
module twb_am_seq
   import twb_am_pkg::*;
#(
   parameter int ADDR_W = 7
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start_p,
   input  logic            stop_p,
   input  logic            scl_rise,
   input  logic            scl_fall,
   input  logic            sda_s,
   input  logic            hit,
   output logic [ADDR_W:0] rx_byte,
   output logic            sda_pull,
   output logic            hit_evt
);
   localparam int CW = $clog2(ADDR_W + 1);
   localparam logic [CW-1:0] LAST = CW'(ADDR_W);

   am_state_e      state;
   logic [CW-1:0]  cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         cnt     <= '0;
         rx_byte <= '0;
         hit_evt <= 1'b0;
      end else begin
         hit_evt <= 1'b0;
         if (start_p) begin
            state <= ST_ADDR;
            cnt   <= '0;
         end else if (stop_p) begin
            state <= ST_IDLE;
         end else begin
            case (state)
               ST_ADDR: if (scl_rise) begin
                  rx_byte <= {rx_byte[ADDR_W-1:0], sda_s};
                  cnt     <= cnt + 1'b1;
                  if (cnt == LAST) state <= ST_WAIT;
               end
               ST_WAIT: if (scl_fall) begin
                  if (hit) begin
                     state   <= ST_ACK;
                     hit_evt <= 1'b1;
                  end else begin
                     state <= ST_IDLE;
                  end
               end
               ST_ACK: if (scl_fall) state <= ST_IDLE;
               default: ;
            endcase
         end
      end
   end

   assign sda_pull = (state == ST_ACK);
endmodule

// File: rtl/twb_addr_match.sv
module twb_addr_match
   import twb_am_pkg::*;
#(
   parameter int ADDR_W      = 7,
   parameter int SYNC_STAGES = 2,
   parameter bit GC_SUPPORT  = 1'b1,
   parameter int REG_AW      = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_we,
   input  logic [REG_AW-1:0]   reg_addr,
   input  logic [ADDR_W:0]     reg_wdata,
   output logic [ADDR_W:0]     reg_rdata,
   input  logic                scl_in,
   input  logic                sda_in,
   output logic                sda_pull,
   output logic                irq
);
   localparam int DW = ADDR_W + 1;

   generate
      if (ADDR_W < 1) begin : g_bad_aw
         $error("twb_addr_match: ADDR_W must be at least 1");
      end
      if ((1 << REG_AW) <= OFS_STAT) begin : g_bad_raw
         $error("twb_addr_match: REG_AW too small for three offsets");
      end
   endgenerate

   logic              scl_s, sda_s, start_p, stop_p, scl_rise, scl_fall;
   logic [ADDR_W:0]   rx_byte;
   logic              own_hit, gc_hit, hit_evt;
   logic [ADDR_W-1:0] own_q, mask_q;
   logic              gce_q;
   logic              st_match, st_dir, st_gc;
   logic              wr_own, wr_mask, wr_stat;

   assign wr_own  = reg_we && (reg_addr == REG_AW'(OFS_OWN));
   assign wr_mask = reg_we && (reg_addr == REG_AW'(OFS_MASK));
   assign wr_stat = reg_we && (reg_addr == REG_AW'(OFS_STAT));

   twb_am_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
      .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
      .scl_s(scl_s), .sda_s(sda_s), .start_p(start_p), .stop_p(stop_p),
      .scl_rise(scl_rise), .scl_fall(scl_fall)
   );

   twb_am_cmp #(.ADDR_W(ADDR_W), .GC_SUPPORT(GC_SUPPORT)) u_cmp (
      .own_addr(own_q), .mask(mask_q), .gc_en(gce_q),
      .rx_addr(rx_byte[ADDR_W:1]), .own_hit(own_hit), .gc_hit(gc_hit)
   );

   twb_am_seq #(.ADDR_W(ADDR_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .start_p(start_p), .stop_p(stop_p),
      .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_s(sda_s),
      .hit(own_hit | gc_hit), .rx_byte(rx_byte), .sda_pull(sda_pull),
      .hit_evt(hit_evt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         own_q  <= '1;
         mask_q <= '0;
      end else begin
         if (wr_own)  own_q  <= reg_wdata[DW-1:1];
         if (wr_mask) mask_q <= reg_wdata[DW-1:1];
      end
   end

   generate
      if (GC_SUPPORT) begin : g_gce
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      gce_q <= 1'b0;
            else if (wr_own) gce_q <= reg_wdata[0];
         end
      end else begin : g_no_gce
         assign gce_q = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_match <= 1'b0;
         st_dir   <= 1'b0;
         st_gc    <= 1'b0;
      end else if (hit_evt) begin
         st_match <= 1'b1;
         st_dir   <= rx_byte[0];
         st_gc    <= gc_hit;
      end else if (wr_stat) begin
         st_match <= 1'b0;
         st_dir   <= 1'b0;
         st_gc    <= 1'b0;
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         REG_AW'(OFS_OWN):  reg_rdata = {own_q, gce_q};
         REG_AW'(OFS_MASK): reg_rdata = {mask_q, 1'b0};
         REG_AW'(OFS_STAT): begin
            reg_rdata[STB_MATCH] = st_match;
            reg_rdata[STB_DIR]   = st_dir;
            reg_rdata[STB_GC]    = st_gc;
         end
         default: ;
      endcase
   end

   assign irq = st_match;
endmodule

// File: rtl/twb_am_chk.sv
module twb_am_chk #(
   parameter int DW     = 8,
   parameter int REG_AW = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_we,
   input logic [REG_AW-1:0] reg_addr,
   input logic [DW-1:0]     reg_rdata,
   input logic              sda_pull,
   input logic              irq,
   input logic              scl_s,
   input logic              start_p,
   input logic              hit_evt
);
   assert_mask_lsb_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == REG_AW'(1)) |-> (reg_rdata[0] == 1'b0));

   assert_ack_scl_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_pull) |-> !scl_s);

   assert_irq_after_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> (sda_pull && $past(sda_pull)));

   assert_ack_needs_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_pull) |-> hit_evt);

   assert_start_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
      start_p |=> !sda_pull);

   assert_clear_drops_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == REG_AW'(2) && !hit_evt) |=> !irq);
endmodule

bind twb_addr_match twb_am_chk #(.DW(DW), .REG_AW(REG_AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
   .reg_rdata(reg_rdata), .sda_pull(sda_pull), .irq(irq), .scl_s(scl_s),
   .start_p(start_p), .hit_evt(hit_evt)
);

// File: tb/sim_twb_addr_match.sv
`timescale 1ns/1ps
module sim_twb_addr_match;
   localparam int Q = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_we = 1'b0;
   logic [1:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       scl = 1'b1, sda_m = 1'b1;
   logic       sda_line, sda_pull, irq;
   int         checks = 0, errors = 0;
   bit         done = 1'b0;

   always #5 clk = ~clk;
   assign sda_line = sda_m & ~sda_pull;

   twb_addr_match u0 (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .scl_in(scl),
      .sda_in(sda_line), .sda_pull(sda_pull), .irq(irq)
   );

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wait_clk(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(logic [1:0] a, logic [7:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic bus_start();
      sda_m = 1'b1; wait_clk(Q);
      scl = 1'b1;   wait_clk(Q);
      sda_m = 1'b0; wait_clk(Q);
      scl = 1'b0;   wait_clk(Q);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; wait_clk(Q);
      scl = 1'b1;   wait_clk(Q);
      sda_m = 1'b1; wait_clk(Q);
   endtask

   task automatic bus_bit(logic b);
      sda_m = b;  wait_clk(Q);
      scl = 1'b1; wait_clk(2 * Q);
      scl = 1'b0; wait_clk(Q);
   endtask

   task automatic send_byte(logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) bus_bit(b[i]);
      sda_m = 1'b1; wait_clk(Q);
      scl = 1'b1;   wait_clk(Q);
      ack = ~sda_line;
      wait_clk(Q);
      scl = 1'b0;   wait_clk(Q);
   endtask

   task automatic t_reset();
      logic [7:0] d;
      rd(2'd0, d); chk("R1 own reset", d, 8'hFE);
      rd(2'd1, d); chk("R1 mask reset", d, 8'h00);
      rd(2'd2, d); chk("R1 status reset", d, 8'h00);
      chk("R1 pull reset", sda_pull, 0);
      chk("R1 irq reset", irq, 0);
   endtask

   task automatic t_mask_lsb();
      logic [7:0] d;
      wr(2'd1, 8'hFF);
      rd(2'd1, d); chk("R2 mask lsb reads zero", d, 8'hFE);
      wr(2'd1, 8'h00);
   endtask

   task automatic t_exact();
      logic ack; logic [7:0] d;
      wr(2'd0, 8'h54);
      bus_start(); send_byte(8'h55, ack); bus_stop();
      chk("R3 ack on own address", ack, 1);
      chk("R3 irq on match", irq, 1);
      rd(2'd2, d); chk("R7 status match+dir", d, 8'h03);
      wr(2'd2, 8'h00);
      rd(2'd2, d); chk("R9 status cleared", d, 8'h00);
      chk("R9 irq dropped", irq, 0);
   endtask

   task automatic t_mismatch();
      logic ack; logic [7:0] d;
      bus_start(); send_byte(8'h56, ack);
      chk("R4 no ack on mismatch", ack, 0);
      send_byte(8'h54, ack);
      chk("R10 ignored until START", ack, 0);
      bus_stop();
      chk("R4 irq stays low", irq, 0);
      rd(2'd2, d); chk("R4 status untouched", d, 8'h00);
   endtask

   task automatic t_mask();
      logic ack; logic [7:0] d;
      wr(2'd1, 8'h06);
      bus_start(); send_byte(8'h52, ack); bus_stop();
      chk("R5 masked bits ignored", ack, 1);
      rd(2'd2, d); chk("R7 dir zero captured", d, 8'h01);
      wr(2'd2, 8'h00);
      bus_start(); send_byte(8'h58, ack); bus_stop();
      chk("R5 unmasked bit still compared", ack, 0);
      wr(2'd1, 8'h00);
   endtask

   task automatic t_gc();
      logic ack; logic [7:0] d;
      wr(2'd0, 8'h55);
      bus_start(); send_byte(8'h00, ack); bus_stop();
      chk("R6 general call acked", ack, 1);
      rd(2'd2, d); chk("R6 general call flag", d, 8'h05);
      wr(2'd2, 8'h00);
      wr(2'd0, 8'h54);
      bus_start(); send_byte(8'h00, ack); bus_stop();
      chk("R6 general call disabled", ack, 0);
      chk("R6 irq low when disabled", irq, 0);
   endtask

   task automatic t_rstart();
      logic ack; logic [7:0] d;
      bus_start();
      bus_bit(1'b1); bus_bit(1'b0); bus_bit(1'b1);
      bus_start(); send_byte(8'h54, ack); bus_stop();
      chk("R8 repeated START restarts", ack, 1);
      rd(2'd2, d); chk("R8 status after restart", d, 8'h01);
      wr(2'd2, 8'h00);
   endtask

   initial begin
      wait_clk(5);
      rst_n = 1'b1;
      wait_clk(5);
      t_reset();
      t_mask_lsb();
      t_exact();
      t_mismatch();
      t_mask();
      t_gc();
      t_rstart();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL R3 watchdog actual=running expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule